// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a pipelined synchronous SRAM in which every access has the same shape. The address and the command are sampled on one rising clock edge, and the data moves on the edge two cycles later, whether the access is a read or a write. Because reads and writes have the same latency, a read can follow a write, and a write can follow a read, on consecutive cycles without an idle slot on the data bus.

The bidirectional data bus is split into a data-in port, a data-out port and a bus-drive flag. A surrounding pad ring or test harness combines them into a tri-state bus. A two-bit burst generator lets one loaded address produce up to four consecutive accesses, in either linear or interleaved order.

A clock enable freezes the whole pipeline, and a sleep input does the same. An asynchronous output enable can silence the bus at any time. A deselect command stops new accesses from starting but lets accesses already in flight finish. The storage is a small parameterized register array.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded or advanced at enabled edge n places the word at its address on `dout` after enabled edge n+2, with `dout_en` high when `oe_n` is low. The word stays there until the next data phase.
- R2: For a write issued at enabled edge n, the `din` value present at enabled edge n+2 is stored. Byte k, which is bits [9k+8:9k], is stored only when `bw_n[k]` was 0 at edge n. All other bytes keep their old value.
- R3: A read issued on the cycle after a write to the same address returns the merged word that the write produced, with no idle cycle between the two commands.
- R4: After enabled edge n+2, `dout_en` is low if the command slot at edge n was a write, a deselect, or no operation.
- R5: While `cen_n` is high, every input is ignored. No pipeline stage, burst state, array word or output changes.
- R6: A load cycle (`adv_ld_n` = 0) with any chip enable false (`ce1_n`=1, `ce2`=0 or `ce3_n`=1) starts no access and ends any burst. Accesses issued before it still complete.
- R7: Byte enables are ignored on reads. A read leaves the array unchanged whatever `bw_n` holds.
- R8: `oe_n` high forces `dout_en` low at once, without a clock edge. It does not disturb the pipeline, so the pending data appears again when `oe_n` returns low.
- R9: `adv_ld_n` high after a selected load continues the burst with the same read or write type. Advance k (1 to 3, then wrapping) uses address bits [1:0] equal to base+k mod 4 when `lin_order`=1, or base XOR k when `lin_order`=0. The upper address bits stay those of the base. Byte enables are sampled on every burst write cycle.
- R10: `adv_ld_n` high when no burst is active (after reset or after a deselect) starts no access.
- R11: While `sleep` is high, the block behaves as if `cen_n` were high. Stored contents are retained.
- R12: After reset, both pipeline stages are empty and `dout_en` is low until the first read reaches its data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline and burst state |
| cen_n | input | 1 | Active-low clock enable |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Active-low chip enable |
| adv_ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write, sampled on load cycles |
| bw_n | input | NB (4) | Active-low byte write enables, one per 9-bit byte |
| addr | input | AW (6) | Word address |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved; held static |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | High gates all state updates |
| din | input | NB*9 (36) | Write data for the data phase |
| dout | output | NB*9 (36) | Read data |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
A wrong pipeline stage or burst state does not stay hidden for long. It shows at the ports two enabled cycles after the faulty command, as `dout_en` asserted in a write or deselect slot, or as a read word taken from the wrong address. A corrupted array byte, or a write that ignored its byte enables, shows only on a later read of that word. For that reason every address is filled first, and each write is followed by a read-back. Stalls through `cen_n` or `sleep` must leave `dout` and `dout_en` frozen on the very next sample, so a stage that moves during a stall is caught on the same cycle.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW     = 6,
  parameter int NB     = 4,
  parameter int BYTE_W = 9,
  localparam int DW    = NB * BYTE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          adv_ld_n,
  input  logic          rd_wr_n,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  input  logic          lin_order,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  logic [DW-1:0] mem [DEPTH];

  logic          b_act, b_rd;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic          s1_v, s1_rd, s2_v, s2_rd;
  logic [AW-1:0] s1_a, s2_a;
  logic [NB-1:0] s1_bw, s2_bw;
  logic          drv_q;
  logic [DW-1:0] q;

  wire en   = !cen_n && !sleep;
  wire sel  = !ce1_n && ce2 && !ce3_n;
  wire load = !adv_ld_n && sel;
  wire adv  = adv_ld_n && b_act;

  wire [1:0] nxt_cnt = b_cnt + 2'd1;
  wire [1:0] nxt_lo  = lin_order ? (b_base[1:0] + nxt_cnt) : (b_base[1:0] ^ nxt_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_rd  <= 1'b0;
      s1_a   <= '0;
      s1_bw  <= '1;
      s2_v   <= 1'b0;
      s2_rd  <= 1'b0;
      s2_a   <= '0;
      s2_bw  <= '1;
      b_act  <= 1'b0;
      b_rd   <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
      drv_q  <= 1'b0;
    end else if (en) begin
      s2_v  <= s1_v;
      s2_rd <= s1_rd;
      s2_a  <= s1_a;
      s2_bw <= s1_bw;
      s1_v  <= load || adv;
      s1_rd <= load ? rd_wr_n : b_rd;
      s1_a  <= load ? addr : {b_base[AW-1:2], nxt_lo};
      s1_bw <= bw_n;
      if (!adv_ld_n) begin
        b_act  <= sel;
        b_base <= addr;
        b_cnt  <= '0;
        b_rd   <= rd_wr_n;
      end else if (b_act) begin
        b_cnt <= nxt_cnt;
      end
      drv_q <= s2_v && s2_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (en && s2_v) begin
      if (s2_rd) begin
        q <= mem[s2_a];
      end else begin
        for (int b = 0; b < NB; b++)
          if (!s2_bw[b]) mem[s2_a][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign dout    = q;
  assign dout_en = drv_q && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen_n,
  input logic          sleep,
  input logic          adv_ld_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          oe_n,
  input logic          b_act,
  input logic          s1_v,
  input logic [AW-1:0] s1_a,
  input logic          s2_v,
  input logic          s2_rd,
  input logic          drv_q,
  input logic [DW-1:0] q,
  input logic          dout_en
);
  wire en  = !cen_n && !sleep;
  wire sel = !ce1_n && ce2 && !ce3_n;

  a_r1_read_launch: assert property (@(posedge clk) disable iff (!rst_n)
    en && s2_v && s2_rd |=> drv_q);
  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    en && !(s2_v && s2_rd) |=> !drv_q);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(drv_q) && $stable(q) && $stable(s1_v) && $stable(s2_v));
  a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    en && !adv_ld_n && !sel |=> !s1_v && !b_act);
  a_r10_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv_ld_n && !b_act |=> !s1_v);
  a_r9_burst_page: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv_ld_n && b_act |=> s1_v && $stable(s1_a[AW-1:2]));
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep), .adv_ld_n(adv_ld_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n), .b_act(b_act),
  .s1_v(s1_v), .s1_a(s1_a), .s2_v(s2_v), .s2_rd(s2_rd), .drv_q(drv_q),
  .q(q), .dout_en(dout_en)
);

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] DES = 3'b000;

  logic clk = 1'b0;
  logic rst_n, cen_n, ce1_n, ce2, ce3_n, adv_ld_n, rd_wr_n, lin_order, oe_n, sleep;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en;

  always #4 clk = ~clk;

  zbt_sram dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld_n(adv_ld_n), .rd_wr_n(rd_wr_n), .bw_n(bw_n), .addr(addr),
    .lin_order(lin_order), .oe_n(oe_n), .sleep(sleep), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] refmem [1<<AW];
  logic m_v1 = 0, m_rd1 = 0, m_v2 = 0, m_rd2 = 0, m_drv = 0;
  logic [AW-1:0] m_a1 = 0, m_a2 = 0;
  logic [3:0] m_bw1 = 0, m_bw2 = 0;
  logic [DW-1:0] m_q = 0;
  logic b_act = 0, b_rd = 0;
  logic [AW-1:0] b_base = 0;
  logic [1:0] b_cnt = 0;

  function automatic logic [15:0] mk(logic c, logic [2:0] ce, logic ad, logic r,
                                     logic [3:0] bw, logic [5:0] a);
    return {c, ce, ad, r, bw, a};
  endfunction

  localparam logic [15:0] VEC [16] = '{
    mk(0, SEL, 0, 0, 4'h0, 6'd10), mk(0, SEL, 0, 1, 4'h0, 6'd10),
    mk(0, SEL, 0, 0, 4'hC, 6'd11), mk(0, SEL, 0, 1, 4'hF, 6'd11),
    mk(0, SEL, 0, 1, 4'h0, 6'd10), mk(0, SEL, 0, 0, 4'h0, 6'd12),
    mk(0, SEL, 0, 0, 4'h5, 6'd13), mk(0, SEL, 0, 1, 4'h0, 6'd12),
    mk(0, SEL, 0, 1, 4'h0, 6'd13), mk(1, SEL, 0, 1, 4'h0, 6'd5),
    mk(0, SEL, 0, 1, 4'h0, 6'd5),  mk(0, DES, 0, 1, 4'h0, 6'd6),
    mk(0, SEL, 0, 1, 4'h0, 6'd14), mk(0, SEL, 0, 0, 4'h3, 6'd14),
    mk(0, SEL, 0, 1, 4'h0, 6'd14), mk(0, DES, 0, 0, 4'h0, 6'd14)
  };

  task automatic model_edge(input logic [2:0] ce, input logic ad, input logic r,
                            input logic [3:0] bw, input logic [AW-1:0] a);
    logic [1:0] nc, lo;
    if (m_v2 && !m_rd2)
      for (int b = 0; b < 4; b++)
        if (!m_bw2[b]) refmem[m_a2][b*9 +: 9] = din[b*9 +: 9];
    m_drv = m_v2 && m_rd2;
    if (m_v2 && m_rd2) m_q = refmem[m_a2];
    m_v2 = m_v1; m_rd2 = m_rd1; m_a2 = m_a1; m_bw2 = m_bw1;
    m_bw1 = bw;
    if (!ad) begin
      m_v1 = (ce == SEL); m_rd1 = r; m_a1 = a;
      b_act = (ce == SEL); b_base = a; b_cnt = 0; b_rd = r;
    end else if (b_act) begin
      nc = b_cnt + 2'd1;
      lo = lin_order ? (b_base[1:0] + nc) : (b_base[1:0] ^ nc);
      b_cnt = nc;
      m_v1 = 1; m_rd1 = b_rd; m_a1 = {b_base[AW-1:2], lo};
    end else begin
      m_v1 = 0;
    end
  endtask

  task automatic chk(input string tag);
    logic exp_en;
    exp_en = m_drv && !oe_n;
    checks++;
    if (dout_en !== exp_en) begin
      fails++;
      $display("FAIL %s dout_en actual=%b expected=%b at cycle %0d", tag, dout_en, exp_en, cyc);
    end
    if (exp_en) begin
      checks++;
      if (dout !== m_q) begin
        fails++;
        $display("FAIL %s dout actual=%h expected=%h at cycle %0d", tag, dout, m_q, cyc);
      end
    end
  endtask

  task automatic step(input logic c, input logic [2:0] ce, input logic ad, input logic r,
                      input logic [3:0] bw, input logic [AW-1:0] a, input logic o,
                      input logic s, input string tag);
    cen_n = c; {ce1_n, ce2, ce3_n} = ce; adv_ld_n = ad; rd_wr_n = r;
    bw_n = bw; addr = a; oe_n = o; sleep = s;
    din = {4'h5, cyc[15:0] ^ 16'h3C5A, ~cyc[15:0]};
    cyc++;
    @(posedge clk);
    if (!c && !s) model_edge(ce, ad, r, bw, a);
    @(negedge clk);
    chk(tag);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3; i++) step(0, DES, 0, 1, 4'hF, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cen_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adv_ld_n = 1; rd_wr_n = 1;
    bw_n = 4'hF; addr = 0; lin_order = 1; oe_n = 0; sleep = 0; din = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (dout_en !== 1'b0) begin
      fails++;
      $display("FAIL R12 dout_en in reset actual=%b expected=0", dout_en);
    end
    rst_n = 1;
    // R12: adv high with empty pipeline, then first read reaches bus after two edges
    step(0, SEL, 1, 1, 4'hF, 0, 0, 0, "R12");
    step(0, SEL, 0, 1, 4'hF, 0, 0, 0, "R12");
    step(0, SEL, 0, 1, 4'hF, 1, 0, 0, "R12");
    drain("R12");
    // R2: fill every word with full-width writes
    for (int i = 0; i < (1 << AW); i++) step(0, SEL, 0, 0, 4'h0, i[AW-1:0], 0, 0, "R2");
    drain("R2");
    // R1 / R4: table of mixed traffic
    for (int i = 0; i < 16; i++)
      step(VEC[i][15], VEC[i][14:12], VEC[i][11], VEC[i][10], VEC[i][9:6], VEC[i][5:0],
           0, 0, "R1");
    drain("R4");
    // R2: partial byte write then read back
    step(0, SEL, 0, 0, 4'b1010, 9, 0, 0, "R2");
    step(0, SEL, 0, 1, 4'hF, 9, 0, 0, "R2");
    drain("R2");
    // R3: write then immediate read, twice with alternation
    step(0, SEL, 0, 0, 4'b0110, 20, 0, 0, "R3");
    step(0, SEL, 0, 1, 4'hF, 20, 0, 0, "R3");
    step(0, SEL, 0, 0, 4'h0, 21, 0, 0, "R3");
    step(0, SEL, 0, 1, 4'hF, 21, 0, 0, "R3");
    drain("R3");
    // R4: write slot between reads leaves bus undriven
    step(0, SEL, 0, 1, 4'hF, 2, 0, 0, "R4");
    step(0, SEL, 0, 0, 4'h0, 3, 0, 0, "R4");
    step(0, SEL, 0, 1, 4'hF, 3, 0, 0, "R4");
    drain("R4");
    // R5: stalls during read and write data phases
    step(0, SEL, 0, 1, 4'hF, 4, 0, 0, "R5");
    step(0, SEL, 0, 0, 4'h0, 30, 0, 0, "R5");
    step(0, SEL, 0, 1, 4'hF, 7, 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, SEL, 0, 0, 4'h0, 31, 0, 0, "R5");
    step(0, SEL, 0, 1, 4'hF, 30, 0, 0, "R5");
    step(0, SEL, 0, 1, 4'hF, 31, 0, 0, "R5");
    drain("R5");
    // R6: deselect right after two reads lets them finish
    step(0, SEL, 0, 1, 4'hF, 40, 0, 0, "R6");
    step(0, SEL, 0, 1, 4'hF, 41, 0, 0, "R6");
    step(0, 3'b110, 0, 1, 4'hF, 42, 0, 0, "R6");
    step(0, 3'b011, 0, 1, 4'hF, 42, 0, 0, "R6");
    step(0, 3'b000, 0, 0, 4'h0, 43, 0, 0, "R6");
    drain("R6");
    step(0, SEL, 0, 1, 4'hF, 43, 0, 0, "R6");
    drain("R6");
    // R7: read with all byte enables active changes nothing
    step(0, SEL, 0, 1, 4'h0, 22, 0, 0, "R7");
    step(0, SEL, 0, 1, 4'h0, 22, 0, 0, "R7");
    step(0, SEL, 0, 1, 4'hF, 22, 0, 0, "R7");
    drain("R7");
    // R8: output enable gates bus without disturbing pipeline
    step(0, SEL, 0, 1, 4'hF, 23, 0, 0, "R8");
    step(0, SEL, 1, 1, 4'hF, 0, 1, 0, "R8");
    step(0, SEL, 1, 1, 4'hF, 0, 1, 0, "R8");
    step(1, SEL, 1, 1, 4'hF, 0, 0, 0, "R8");
    drain("R8");
    // R9: linear bursts, read and write with changing byte enables
    lin_order = 1;
    step(0, SEL, 0, 0, 4'h0, 6'd46, 0, 0, "R9");
    step(0, SEL, 1, 1, 4'b1110, 0, 0, 0, "R9");
    step(0, SEL, 1, 1, 4'b0111, 0, 0, 0, "R9");
    step(0, SEL, 1, 1, 4'h0, 0, 0, 0, "R9");
    step(0, SEL, 0, 1, 4'hF, 6'd45, 0, 0, "R9");
    for (int i = 0; i < 5; i++) step(0, SEL, 1, 0, 4'hF, 0, 0, 0, "R9");
    drain("R9");
    // R9: interleaved burst read
    lin_order = 0;
    step(0, SEL, 0, 1, 4'hF, 6'd46, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, SEL, 1, 1, 4'hF, 0, 0, 0, "R9");
    step(0, SEL, 0, 0, 4'h0, 6'd49, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, SEL, 1, 1, 4'h0, 0, 0, 0, "R9");
    step(0, SEL, 0, 1, 4'hF, 6'd48, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, SEL, 1, 1, 4'hF, 0, 0, 0, "R9");
    drain("R9");
    lin_order = 1;
    // R10: advance after deselect starts nothing
    step(0, SEL, 0, 1, 4'hF, 50, 0, 0, "R10");
    step(0, DES, 0, 1, 4'hF, 50, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, SEL, 1, 0, 4'h0, 51, 0, 0, "R10");
    step(0, SEL, 0, 1, 4'hF, 51, 0, 0, "R10");
    drain("R10");
    // R11: sleep freezes state and blocks a write
    step(0, SEL, 0, 1, 4'hF, 52, 0, 0, "R11");
    for (int i = 0; i < 3; i++) step(0, SEL, 0, 0, 4'h0, 53, 0, 1, "R11");
    step(0, SEL, 1, 1, 4'hF, 0, 0, 0, "R11");
    step(0, SEL, 0, 1, 4'hF, 53, 0, 0, "R11");
    drain("R11");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule